// File: doc/BRIEF.md
# Debug-Aware Capture/Compare Timer

This block is a 16-bit timer peripheral with a free-running up-counter, a programmable wrap value and two channels. A small byte-wide register port lets software set the prescaler, stop or restart the counter, program the wrap value and configure each channel. Each channel works either as an input capture, which latches the counter on a chosen pin edge, or as an output compare, which drives its pin when the counter reaches the channel value. Channel 0 can also pair itself with channel 1's value register. This gives a double-buffered compare or a double-buffered PWM, where the active duty value changes only at the counter wrap.

Every status flag (the overflow flag and one flag per channel) is cleared in two steps. Software first reads the register while the flag is set, and then writes the flag bit as 0. A debug halt input freezes the counter and blocks captures. While it is high, the flags are also protected, unless a separate clear-permit input is set.

Top module: `capcmp_timer`

Register map (4-bit address, 8-bit data):

| Addr | Register | Contents |
|---|---|---|
| 0 | control/status | bit 7 overflow flag, bit 6 overflow interrupt enable, bit 5 stop, bit 4 counter restart (write-only, reads 0), bits 2:0 prescale select |
| 1, 2 | counter | high byte, low byte (read-only) |
| 3, 4 | wrap value | high byte, low byte |
| 5 / 8 | channel 0 / 1 control | bit 7 flag, bit 6 interrupt enable, bits 3:2 mode, bits 1:0 edge or action |
| 6, 7 / 9, 10 | channel 0 / 1 value | high byte, low byte |

Channel mode codes: 00 capture, 01 compare, 10 buffered compare, 11 buffered PWM. Codes 10 and 11 apply to channel 0 only; on channel 1, bit 3 is stored as 0.

## Requirements
- R1: After reset, the control register reads 0x20 (stopped, prescale 0, flag and enable clear). The counter reads 0x0000, the wrap value reads 0xFFFF, and both pins and all interrupt outputs are 0.
- R2: While running, the counter advances once every 2^s clock cycles, where s is the prescale select (values 6 and 7 both give 64). While the stop bit is set, the counter holds its value.
- R3: On a tick at which the counter equals the wrap value, the counter returns to 0x0000 and the overflow flag is set. irq_ovf is high while both the flag and bit 6 are set.
- R4: Writing 1 to control bit 4 clears the counter and the prescaler to zero.
- R5: A flag is cleared only by a write of 0 to its bit that follows a read of that register made while the flag was set. Writing 0 without that read leaves the flag set.
- R6: While brk is high, the counter holds its value and no input capture is recorded, whatever the pin does.
- R7: While brk is high and brk_clr_en is 0, reads do not arm a clear and writes do not clear a flag. A read made before the halt still completes with a write of 0 after the halt ends.
- R8: While brk is high and brk_clr_en is 1, the two-step clear works. A flag cleared this way stays clear after brk falls.
- R9: In capture mode, a channel copies the counter into its value register and sets its flag on the selected edge of its synchronised pin: action code 01 selects rising edges, 10 falling edges and 11 both.
- R10: In compare mode, the step to the channel value toggles the pin (code 01), clears it (10) or sets it (11), and sets the channel flag.
- R11: In buffered PWM mode, the channel 0 pin goes high when the counter wraps and low at the compare match. The compare value comes from whichever of the two value registers was written last, and it is switched only at a wrap. Channel 1's pin stays 0 while channel 0 is buffered.
- R12: Configuration fields read back as written, except for the write-only restart bit and channel 1's mode bit 3, which read 0. Writing 1 to a flag bit never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (arms flag clears) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| cap_in | input | 2 | Channel capture pins |
| cmp_out | output | 2 | Channel compare/PWM pins |
| brk | input | 1 | Debug halt |
| brk_clr_en | input | 1 | Permit flag clears during halt |
| irq_ovf | output | 1 | Overflow interrupt |
| irq_ch | output | 2 | Channel interrupts |

## Verification
The hardest case to reach is a two-step clear that the debug halt splits in two. The flag must first be set by a real overflow. The arming read must then occur before brk rises, and the completing write must occur after it falls. The stimulus sets the wrap value to 5 and runs until irq_ovf rises. It stops the counter and performs the read, then holds brk through a write of 0. Next it releases brk and writes 0 again. It repeats this with the read inside the halt, and again with brk_clr_en set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int AW  = 4;
    localparam int DW  = 8;
    localparam int CW  = 16;
    localparam int NCH = 2;
    localparam int PSW = 3;
    localparam int DIVW = 6;

    localparam logic [AW-1:0] A_CTRL  = 4'd0;
    localparam logic [AW-1:0] A_CNTH  = 4'd1;
    localparam logic [AW-1:0] A_CNTL  = 4'd2;
    localparam logic [AW-1:0] A_MODH  = 4'd3;
    localparam logic [AW-1:0] A_MODL  = 4'd4;
    localparam logic [AW-1:0] A_CH0   = 4'd5;

    typedef enum logic [1:0] {
        M_CAP  = 2'b00,
        M_CMP  = 2'b01,
        M_BCMP = 2'b10,
        M_BPWM = 2'b11
    } ch_mode_e;

    typedef struct packed {
        logic           flag;
        logic           ovie;
        logic           stop;
        logic [PSW-1:0] ps;
    } ctrl_t;

    typedef struct packed {
        logic     flag;
        logic     ie;
        ch_mode_e mode;
        logic [1:0] sel;
    } ch_ctl_t;

    function automatic logic [DIVW-1:0] ps_limit(input logic [PSW-1:0] ps);
        int sh;
        sh = (int'(ps) > DIVW) ? DIVW : int'(ps);
        return DIVW'((1 << sh) - 1);
    endfunction

    function automatic logic [AW-1:0] ch_base(input int idx);
        return AW'(int'(A_CH0) + 3 * idx);
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale import tmr_pkg::*; (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           run,
    input  logic [PSW-1:0] ps,
    output logic           tick
);
    logic [DIVW-1:0] div_q;
    logic [DIVW-1:0] lim;
    logic            at_lim;

    always_comb begin
        lim    = ps_limit(ps);
        at_lim = (div_q >= lim);
        tick   = run & at_lim;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= at_lim ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter import tmr_pkg::*; (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] top_val,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] nxt,
    output logic          wrap
);
    always_comb begin
        wrap = tick && (cnt == top_val);
        nxt  = wrap ? '0 : cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= nxt;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pkg::*; #(
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pin_in,
    input  logic          brk,
    input  logic          idle,
    input  ch_mode_e      mode,
    input  logic [1:0]    sel,
    input  logic          tick,
    input  logic          wrap,
    input  logic [CW-1:0] nxt,
    input  logic [CW-1:0] cmp_val,
    output logic          cap_evt,
    output logic          cmp_evt,
    output logic          pin_out
);
    logic [SYNC-1:0] sync_q;
    logic            prev_q;
    logic            rise, fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], pin_in};
            prev_q <= sync_q[SYNC-1];
        end
    end

    always_comb begin
        rise    = sync_q[SYNC-1] & ~prev_q;
        fall    = ~sync_q[SYNC-1] & prev_q;
        cap_evt = !idle && (mode == M_CAP) && !brk &&
                  ((sel[0] & rise) | (sel[1] & fall));
        cmp_evt = !idle && (mode != M_CAP) && tick && (nxt == cmp_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_out <= 1'b0;
        end else if (idle || mode == M_CAP) begin
            pin_out <= 1'b0;
        end else if (mode == M_BPWM) begin
            if (cmp_evt)      pin_out <= 1'b0;
            else if (wrap)    pin_out <= 1'b1;
        end else if (cmp_evt) begin
            case (sel)
                2'b01:   pin_out <= ~pin_out;
                2'b10:   pin_out <= 1'b0;
                2'b11:   pin_out <= 1'b1;
                default: pin_out <= pin_out;
            endcase
        end
    end
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer import tmr_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    input  logic [1:0]    cap_in,
    output logic [1:0]    cmp_out,
    input  logic          brk,
    input  logic          brk_clr_en,
    output logic          irq_ovf,
    output logic [1:0]    irq_ch
);
    ctrl_t         ctl_q;
    logic [CW-1:0] modv_q;
    logic [CW-1:0] chv_q   [NCH];
    ch_ctl_t       chc_q   [NCH];
    logic [CW-1:0] cmp_val [NCH];
    logic [NCH-1:0] ch_arm_q;
    logic          ovf_arm_q;
    logic          act_q, last_wr_q;

    logic          prot, wr_ctrl, crst, run, tick, wrap, buffered;
    logic          clr_ovf, ovf_flag, stop_bit;
    logic [CW-1:0] cnt_q, cnt_nxt;
    logic [NCH-1:0] cap_evt, cmp_evt, clr_ch;

    always_comb begin
        prot     = brk & ~brk_clr_en;
        wr_ctrl  = wr_en && (addr == A_CTRL);
        crst     = wr_ctrl && wdata[4];
        stop_bit = ctl_q.stop;
        ovf_flag = ctl_q.flag;
        run      = !ctl_q.stop && !brk;
        buffered = (chc_q[0].mode == M_BCMP) || (chc_q[0].mode == M_BPWM);
        clr_ovf  = wr_ctrl && !wdata[7] && ovf_arm_q && !prot;
        cmp_val[0] = buffered ? chv_q[act_q] : chv_q[0];
        cmp_val[1] = chv_q[1];
        for (int i = 0; i < NCH; i++) begin
            clr_ch[i] = wr_en && (addr == ch_base(i)) && !wdata[7] && ch_arm_q[i] && !prot;
        end
    end

    tmr_prescale u_pre (
        .clk(clk), .rst(rst), .clr(crst), .run(run), .ps(ctl_q.ps), .tick(tick)
    );

    tmr_counter u_cnt (
        .clk(clk), .rst(rst), .clr(crst), .tick(tick), .top_val(modv_q),
        .cnt(cnt_q), .nxt(cnt_nxt), .wrap(wrap)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_channel #(.SYNC(SYNC_STAGES)) u_ch (
            .clk(clk), .rst(rst), .pin_in(cap_in[g]), .brk(brk),
            .idle((g != 0) && buffered),
            .mode(chc_q[g].mode), .sel(chc_q[g].sel),
            .tick(tick), .wrap(wrap), .nxt(cnt_nxt), .cmp_val(cmp_val[g]),
            .cap_evt(cap_evt[g]), .cmp_evt(cmp_evt[g]), .pin_out(cmp_out[g])
        );
        assign irq_ch[g] = chc_q[g].flag & chc_q[g].ie;
    end

    assign irq_ovf = ctl_q.flag & ctl_q.ovie;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= '{flag: 1'b0, ovie: 1'b0, stop: 1'b1, ps: '0};
            modv_q    <= '1;
            ovf_arm_q <= 1'b0;
            ch_arm_q  <= '0;
            act_q     <= 1'b0;
            last_wr_q <= 1'b0;
            for (int i = 0; i < NCH; i++) begin
                chv_q[i] <= '0;
                chc_q[i] <= '{flag: 1'b0, ie: 1'b0, mode: M_CAP, sel: 2'b00};
            end
        end else begin
            if (wr_ctrl) begin
                ctl_q.ovie <= wdata[6];
                ctl_q.stop <= wdata[5];
                ctl_q.ps   <= wdata[PSW-1:0];
            end
            if (wrap)         ctl_q.flag <= 1'b1;
            else if (clr_ovf) ctl_q.flag <= 1'b0;
            if (clr_ovf)
                ovf_arm_q <= 1'b0;
            else if (rd_en && addr == A_CTRL && ctl_q.flag && !prot)
                ovf_arm_q <= 1'b1;

            if (wr_en && addr == A_MODH) modv_q[CW-1:DW] <= wdata;
            if (wr_en && addr == A_MODL) modv_q[DW-1:0]  <= wdata;

            for (int i = 0; i < NCH; i++) begin
                if (wr_en && addr == ch_base(i)) begin
                    chc_q[i].ie   <= wdata[6];
                    chc_q[i].mode <= ch_mode_e'({(i == 0) ? wdata[3] : 1'b0, wdata[2]});
                    chc_q[i].sel  <= wdata[1:0];
                end
                if (cap_evt[i] || cmp_evt[i]) chc_q[i].flag <= 1'b1;
                else if (clr_ch[i])           chc_q[i].flag <= 1'b0;
                if (clr_ch[i])
                    ch_arm_q[i] <= 1'b0;
                else if (rd_en && addr == ch_base(i) && chc_q[i].flag && !prot)
                    ch_arm_q[i] <= 1'b1;

                if (cap_evt[i]) begin
                    chv_q[i] <= cnt_q;
                end else if (wr_en && addr == ch_base(i) + 4'd1) begin
                    chv_q[i][CW-1:DW] <= wdata;
                    last_wr_q <= (i != 0);
                end else if (wr_en && addr == ch_base(i) + 4'd2) begin
                    chv_q[i][DW-1:0] <= wdata;
                    last_wr_q <= (i != 0);
                end
            end

            if (!buffered)  act_q <= 1'b0;
            else if (wrap)  act_q <= last_wr_q;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: rdata = {ctl_q.flag, ctl_q.ovie, ctl_q.stop, 2'b00, ctl_q.ps};
            A_CNTH: rdata = cnt_q[CW-1:DW];
            A_CNTL: rdata = cnt_q[DW-1:0];
            A_MODH: rdata = modv_q[CW-1:DW];
            A_MODL: rdata = modv_q[DW-1:0];
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (addr == ch_base(i))
                        rdata = {chc_q[i].flag, chc_q[i].ie, 2'b00, chc_q[i].mode, chc_q[i].sel};
                    if (addr == ch_base(i) + 4'd1) rdata = chv_q[i][CW-1:DW];
                    if (addr == ch_base(i) + 4'd2) rdata = chv_q[i][DW-1:0];
                end
            end
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker import tmr_pkg::*; (
    input logic          clk,
    input logic          rst,
    input logic          brk,
    input logic          brk_clr_en,
    input logic          wr_en,
    input logic [3:0]    addr,
    input logic [7:0]    wdata,
    input logic [CW-1:0] cnt_q,
    input logic [CW-1:0] modv_q,
    input logic          tick,
    input logic          stop_bit,
    input logic          ovf_flag
);
    logic crst_wr;
    assign crst_wr = wr_en && (addr == A_CTRL) && wdata[4];

    // R6: halt freezes the counter
    assert_halt_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        (brk && !crst_wr) |=> $stable(cnt_q));

    // R2: stop holds the counter
    assert_stop_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (stop_bit && !crst_wr) |=> $stable(cnt_q));

    // R3: wrap to zero with flag
    assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q == modv_q) |=> (cnt_q == '0 && ovf_flag));

    // R7: protected flag survives the halt
    assert_flag_guard_R7: assert property (@(posedge clk) disable iff (rst)
        (brk && !brk_clr_en && ovf_flag) |=> ovf_flag);

    // R5: a flag falls only after a zero write to its register
    assert_clear_by_write_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf_flag) |-> $past(wr_en && addr == A_CTRL && !wdata[7]));
endmodule

bind capcmp_timer tmr_checker u_chk (
    .clk(clk), .rst(rst), .brk(brk), .brk_clr_en(brk_clr_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .cnt_q(cnt_q),
    .modv_q(modv_q), .tick(tick), .stop_bit(stop_bit), .ovf_flag(ovf_flag)
);

// File: tb/test_capcmp_timer.sv
module test_capcmp_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] cap_in = '0;
    logic [1:0] cmp_out;
    logic       brk = 1'b0, brk_clr_en = 1'b0;
    logic       irq_ovf;
    logic [1:0] irq_ch;

    int total = 0;
    int bad = 0;

    // 10 time units per period: 100 MHz with ns units
    always #5 clk = ~clk;

    capcmp_timer i_capcmp_timer (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .cap_in(cap_in), .cmp_out(cmp_out),
        .brk(brk), .brk_clr_en(brk_clr_en), .irq_ovf(irq_ovf), .irq_ch(irq_ch)
    );

    // {addr, write data, expected readback}
    localparam logic [19:0] VEC [10] = '{
        {4'd3,  8'h12, 8'h12}, {4'd4,  8'h34, 8'h34},
        {4'd6,  8'hAB, 8'hAB}, {4'd7,  8'hCD, 8'hCD},
        {4'd9,  8'h55, 8'h55}, {4'd10, 8'hAA, 8'hAA},
        {4'd5,  8'h45, 8'h45}, {4'd8,  8'h4D, 8'h45},
        {4'd0,  8'h37, 8'h27}, {4'd0,  8'hA0, 8'h20}
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_rng(input string tag, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = int'(rdata);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd16(input logic [3:0] a, output int v);
        int hi, lo;
        rd(a, hi);
        rd(a + 4'd1, lo);
        v = hi * 256 + lo;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_to_ovf(output int seen);
        seen = 0;
        wr(4'd0, 8'h40);
        for (int k = 0; k < 40 && seen == 0; k++) begin
            @(negedge clk);
            if (irq_ovf) seen = 1;
        end
        wr(4'd0, 8'h60);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v, a, b, seen, tog, hi_cnt;
        logic prev;
        do_reset();

        // R12: register table
        for (int n = 0; n < 10; n++) begin
            wr(VEC[n][19:16], VEC[n][15:8]);
            rd(VEC[n][19:16], v);
            check($sformatf("R12 vec%0d", n), v, int'(VEC[n][7:0]));
        end

        do_reset();
        // R1: reset state
        rd(4'd0, v);  check("R1 ctrl", v, 8'h20);
        rd16(4'd1, v); check("R1 counter", v, 0);
        rd16(4'd3, v); check("R1 wrap value", v, 16'hFFFF);
        check("R1 pins", int'(cmp_out), 0);
        check("R1 irqs", int'({irq_ovf, irq_ch}), 0);

        // R2: prescale by 8
        wr(4'd0, 8'h33); wr(4'd0, 8'h03);
        repeat (80) @(negedge clk);
        wr(4'd0, 8'h23);
        rd16(4'd1, v); check_rng("R2 divide by 8", v, 9, 11);
        rd16(4'd1, a); check("R2 stop holds", a, v);
        // R2: select 7 acts as 64
        wr(4'd0, 8'h37); wr(4'd0, 8'h07);
        repeat (200) @(negedge clk);
        wr(4'd0, 8'h27);
        rd16(4'd1, v); check_rng("R2 divide by 64", v, 2, 4);
        // R4: restart
        wr(4'd0, 8'h30);
        rd16(4'd1, v); check("R4 restart clears", v, 0);

        // R6: halt freezes counting
        wr(4'd0, 8'h00);
        repeat (5) @(negedge clk);
        brk = 1'b1;
        rd16(4'd1, a);
        repeat (10) @(negedge clk);
        rd16(4'd1, b);
        check("R6 counter frozen", b, a);
        brk = 1'b0;
        repeat (10) @(negedge clk);
        rd16(4'd1, b);
        check("R2 resumes after halt", int'(b > a), 1);
        wr(4'd0, 8'h20);

        // R3 / R5: overflow and two-step clear
        wr(4'd3, 8'h00); wr(4'd4, 8'h05);
        wr(4'd0, 8'h30);
        run_to_ovf(seen);
        check("R3 irq_ovf raised", seen, 1);
        rd16(4'd1, v); check_rng("R3 counter wrapped", v, 0, 5);
        rd(4'd0, v); check("R5 write without read keeps flag", v, 8'hE0);
        wr(4'd0, 8'h60);
        rd(4'd0, v); check("R5 read then write clears", v, 8'h60);
        check("R3 irq low after clear", int'(irq_ovf), 0);

        // R7: arm before halt, protected during halt
        run_to_ovf(seen);
        rd(4'd0, v); check("R7 flag set", v, 8'hE0);
        brk = 1'b1;
        wr(4'd0, 8'h60);
        rd(4'd0, v); check("R7 clear blocked in halt", v, 8'hE0);
        brk = 1'b0;
        wr(4'd0, 8'h60);
        rd(4'd0, v); check("R7 clear completes after halt", v, 8'h60);

        // R7: read during halt does not arm
        run_to_ovf(seen);
        brk = 1'b1;
        rd(4'd0, v);
        brk = 1'b0;
        wr(4'd0, 8'h60);
        rd(4'd0, v); check("R7 halt read does not arm", v, 8'hE0);

        // R8: clear permitted in halt
        brk = 1'b1; brk_clr_en = 1'b1;
        wr(4'd0, 8'h60);
        rd(4'd0, v); check("R8 clear in halt", v, 8'h60);
        brk = 1'b0; brk_clr_en = 1'b0;
        rd(4'd0, v); check("R8 stays clear", v, 8'h60);

        // R9: capture
        wr(4'd3, 8'hFF); wr(4'd4, 8'hFF);
        wr(4'd0, 8'h30); wr(4'd0, 8'h00);
        repeat (10) @(negedge clk);
        wr(4'd0, 8'h20);
        rd16(4'd1, a);
        wr(4'd8, 8'h01);
        cap_in[1] = 1'b1;
        repeat (5) @(negedge clk);
        rd16(4'd9, v); check("R9 rising capture value", v, a);
        rd(4'd8, v); check("R9 capture flag", v, 8'h81);
        wr(4'd0, 8'h00); repeat (7) @(negedge clk); wr(4'd0, 8'h20);
        rd16(4'd1, b);
        cap_in[1] = 1'b0;
        repeat (5) @(negedge clk);
        rd16(4'd9, v); check("R9 falling ignored in rising mode", v, a);
        wr(4'd8, 8'h03);
        cap_in[1] = 1'b1;
        repeat (5) @(negedge clk);
        rd16(4'd9, v); check("R9 both-edge capture", v, b);
        rd(4'd8, v); wr(4'd8, 8'h03);
        rd(4'd8, v); check("R5 channel flag cleared", v, 8'h03);
        brk = 1'b1;
        cap_in[1] = 1'b0;
        repeat (5) @(negedge clk);
        rd(4'd8, v); check("R6 no capture flag in halt", v, 8'h03);
        rd16(4'd9, v); check("R6 no capture value in halt", v, b);
        brk = 1'b0;

        // R10: compare
        wr(4'd3, 8'h00); wr(4'd4, 8'h09);
        wr(4'd9, 8'h00); wr(4'd10, 8'h04);
        wr(4'd8, 8'h05);
        wr(4'd0, 8'h30); wr(4'd0, 8'h00);
        tog = 0; prev = cmp_out[1];
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (cmp_out[1] != prev) tog++;
            prev = cmp_out[1];
        end
        check("R10 toggle count", tog, 2);
        wr(4'd0, 8'h20);
        rd(4'd8, v); check("R10 compare flag", v, 8'h85);
        wr(4'd8, 8'h07); wr(4'd0, 8'h00);
        repeat (12) @(negedge clk);
        check("R10 set action", int'(cmp_out[1]), 1);
        wr(4'd8, 8'h06);
        repeat (12) @(negedge clk);
        check("R10 clear action", int'(cmp_out[1]), 0);
        wr(4'd0, 8'h20);

        // R11: buffered PWM
        wr(4'd6, 8'h00); wr(4'd7, 8'h03);
        wr(4'd5, 8'h0C);
        wr(4'd0, 8'h30); wr(4'd0, 8'h00);
        repeat (20) @(negedge clk);
        hi_cnt = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (cmp_out[0]) hi_cnt++;
            if (cmp_out[1]) hi_cnt += 1000;
        end
        check("R11 duty from value 0", hi_cnt, 15);
        wr(4'd9, 8'h00); wr(4'd10, 8'h07);
        repeat (20) @(negedge clk);
        hi_cnt = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (cmp_out[0]) hi_cnt++;
            if (cmp_out[1]) hi_cnt += 1000;
        end
        check("R11 duty from value 1", hi_cnt, 35);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule